// File: doc/BRIEF.md
# Bus Transfer Timeout Monitor

This block guards the system bus against cycles that never finish. When an on-chip master begins a transfer, the monitor starts counting bus clocks. Any ending of that cycle stops the count: a normal acknowledge, an error acknowledge or a retry. If the programmed limit runs out first, the monitor drives a one-clock error acknowledge of its own, which closes the stalled cycle.

The limit is an 8-bit step count. Each step lasts a fixed 8 bus clocks, and a step count of zero selects the longest window of 256 steps. A global enable gates the whole monitor. Transfers begun by masters outside the chip are not timed.

Top module: `bus_timeout_mon`

## Requirements
- R1: With `mon_en` high, a rising edge that samples `xfer_start` and `master_int` both high starts a window of N = 8 * `limit` clocks. If nothing ends the cycle, `err_ack_out` is high in the cycle that follows the N-th rising edge after the start edge.
- R2: A `limit` of 0 gives a window of 2048 clocks (256 steps).
- R3: `ack` high at any edge inside the window ends timing, and no error acknowledge is produced for that cycle.
- R4: `err_ack_in` high at any edge inside the window ends timing, and no error acknowledge is produced.
- R5: `retry` high at any edge inside the window ends timing, and no error acknowledge is produced.
- R6: A termination sampled on the very edge at which the window expires suppresses the error acknowledge.
- R7: `err_ack_out` is a single-clock pulse. After it, the monitor stays idle until the next qualifying start.
- R8: A start with `master_int` low is ignored and never leads to an error acknowledge.
- R9: While `mon_en` is low, the count is held clear and `err_ack_out` stays low. A cycle that was being timed when the monitor was disabled is not resumed after it is enabled again.
- R10: A qualifying start while a cycle is being timed restarts the window from zero.
- R11: Synchronous reset `rst` clears the count and the output. A cycle that was being timed at reset never produces an error acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_en | input | 1 | Monitor enable |
| limit | input | 8 | Timeout in steps of 8 clocks; 0 means 256 steps |
| xfer_start | input | 1 | Transfer-start strobe |
| master_int | input | 1 | High when the current start comes from an on-chip master |
| ack | input | 1 | Normal transfer acknowledge |
| err_ack_in | input | 1 | Error acknowledge from the addressed target |
| retry | input | 1 | Retry termination |
| err_ack_out | output | 1 | Generated error acknowledge, one-clock pulse |

## Verification
Some properties are checked on every cycle. The output never lasts more than one clock. A termination or a disable leaves the monitor idle with no pulse. A new start always clears the count. A start from an off-chip master never arms the monitor. Other behaviour needs the bench's directed scenarios to show it: the exact expiry cycle for a given limit, the 2048-clock window for a zero limit, the race between a termination and expiry on the same edge, and the restart shift after a second start.

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
  parameter int LIMIT_W  = 8,
  parameter int PRE_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_en,
  input  logic [LIMIT_W-1:0] limit,
  input  logic               xfer_start,
  input  logic               master_int,
  input  logic               ack,
  input  logic               err_ack_in,
  input  logic               retry,
  output logic               err_ack_out
);

  localparam int CNT_W = LIMIT_W + 1 + PRE_LOG2;

  logic               active;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [LIMIT_W:0]   steps;
  logic [CNT_W-1:0]   span;
  logic               term;
  logic               go;
  logic               expire;

  assign steps   = (limit == '0) ? (LIMIT_W+1)'(1) << LIMIT_W : {1'b0, limit};
  assign span    = {steps, {PRE_LOG2{1'b0}}};
  assign cnt_nxt = cnt + 1'b1;
  assign term    = ack | err_ack_in | retry;
  assign go      = mon_en & xfer_start & master_int;
  assign expire  = active & ~go & ~term & (cnt_nxt >= span);

  always_ff @(posedge clk) begin
    if (rst || !mon_en) begin
      active      <= 1'b0;
      cnt         <= '0;
      err_ack_out <= 1'b0;
    end else begin
      err_ack_out <= expire;
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && (term || expire)) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt_nxt;
      end
    end
  end

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    err_ack_out |=> !err_ack_out);

  assert_pulse_needs_window_R1: assert property (@(posedge clk) disable iff (rst)
    err_ack_out |-> $past(active));

  assert_term_ends_window_R6: assert property (@(posedge clk) disable iff (rst)
    (active && term && !go) |=> (!err_ack_out && !active));

  assert_external_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (!active && xfer_start && !master_int) |=> !active);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (!err_ack_out && cnt == '0 && !active));

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
    go |=> (active && cnt == '0 && !err_ack_out));

endmodule

// File: tb/sim_bus_timeout_mon.sv
`timescale 1ns/1ps
module sim_bus_timeout_mon;

  logic       clk = 1'b0;
  logic       rst;
  logic       mon_en;
  logic [7:0] limit;
  logic       xfer_start, master_int, ack, err_ack_in, retry;
  logic       err_ack_out;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  bus_timeout_mon u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .limit(limit),
    .xfer_start(xfer_start), .master_int(master_int),
    .ack(ack), .err_ack_in(err_ack_in), .retry(retry),
    .err_ack_out(err_ack_out)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic internal);
    @(negedge clk);
    xfer_start = 1'b1;
    master_int = internal;
    @(posedge clk);
    @(negedge clk);
    xfer_start = 1'b0;
    master_int = 1'b0;
  endtask

  task automatic quiet_for(input int n, input string tag);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (err_ack_out) highs++;
    end
    check(highs != 0, 1'b0, tag);
  endtask

  task automatic expect_expiry(input int n, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    check(err_ack_out, 1'b0, {tag, " before expiry"});
    @(posedge clk);
    @(negedge clk);
    check(err_ack_out, 1'b1, {tag, " at expiry"});
    @(posedge clk);
    @(negedge clk);
    check(err_ack_out, 1'b0, {tag, " one cycle later"});
  endtask

  task automatic t_reset;
    rst = 1'b1; mon_en = 1'b1; limit = 8'd2;
    xfer_start = 0; master_int = 0; ack = 0; err_ack_in = 0; retry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(err_ack_out, 1'b0, "R11 reset state");
  endtask

  task automatic t_basic(input logic [7:0] lim, input string tag);
    limit = lim;
    pulse_start(1'b1);
    expect_expiry(8 * lim, tag);
    quiet_for(20, {tag, " idle after pulse R7"});
  endtask

  task automatic t_zero_limit;
    limit = 8'd0;
    pulse_start(1'b1);
    expect_expiry(2048, "R2 zero limit");
    limit = 8'd2;
  endtask

  task automatic t_term(input int which, input int k, input string tag);
    limit = 8'd2;
    pulse_start(1'b1);
    repeat (k - 1) @(posedge clk);
    @(negedge clk);
    case (which)
      0: ack = 1'b1;
      1: err_ack_in = 1'b1;
      default: retry = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    ack = 0; err_ack_in = 0; retry = 0;
    check(err_ack_out, 1'b0, tag);
    quiet_for(24, tag);
  endtask

  task automatic t_external;
    limit = 8'd2;
    pulse_start(1'b0);
    quiet_for(30, "R8 external start ignored");
  endtask

  task automatic t_disabled;
    limit = 8'd2;
    mon_en = 1'b0;
    pulse_start(1'b1);
    quiet_for(30, "R9 start while disabled");
    mon_en = 1'b1;
    pulse_start(1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    mon_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mon_en = 1'b1;
    quiet_for(30, "R9 disable mid-cycle not resumed");
  endtask

  task automatic t_restart;
    limit = 8'd2;
    pulse_start(1'b1);
    repeat (4) @(posedge clk);
    pulse_start(1'b1);
    expect_expiry(16, "R10 restart shifts window");
  endtask

  task automatic t_reset_mid;
    limit = 8'd2;
    pulse_start(1'b1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(err_ack_out, 1'b0, "R11 output after reset");
    quiet_for(30, "R11 reset mid-cycle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic(8'd2, "R1 limit 2");
    t_basic(8'd5, "R1 limit 5");
    t_basic(8'd1, "R1 limit 1");
    t_zero_limit();
    t_term(0, 3, "R3 ack ends window");
    t_term(1, 7, "R4 error ack ends window");
    t_term(2, 10, "R5 retry ends window");
    t_term(0, 16, "R6 ack on expiry edge");
    t_term(2, 16, "R6 retry on expiry edge");
    t_external();
    t_disabled();
    t_restart();
    t_reset_mid();
    t_basic(8'd3, "R1 after reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule